// File: doc/BRIEF.md
# Runtime Programmable Clock Divider with Update Handshake

This block divides an input clock by a power of two chosen at run time. Software programs a three-bit ratio code through a 32-bit control write. The code field sits at a parameterised bit offset, and a companion enable bit sits sixteen places above it. A write that carries the enable bit does not change the output immediately. The new code is parked, and a busy flag rises in a status word. The divider switches to the new ratio only when its internal counter completes a full output period. This keeps runt pulses and shortened phases off the output clock.

Software is expected to poll the busy flag before each write and again afterwards. A write that arrives while an update is still in flight is discarded, so the update already under way completes untouched. A one-cycle error pulse reports the discarded write. For a ratio of one, the input clock itself is routed to the output. For every other ratio the output is a registered square wave with equal high and low times.

Top module: `rt_clkdiv`

## Requirements
- R1: After reset the active code is 0: the output follows the input clock, the busy flag reads 0 and the drop-error output is 0.
- R2: The ratio code occupies bits [SHIFT+FIELD_W-1:SHIFT] of the write data, and its enable bit is bit SHIFT+16. A write with the enable bit set while idle makes busy read 1 from the cycle after the write.
- R3: A write whose enable bit is 0 has no effect: busy stays 0 and the output ratio is unchanged.
- R4: Code k selects a division ratio of 2^k, so codes 0..7 give ratios 1, 2, 4, 8, 16, 32, 64 and 128.
- R5: A parked code becomes active at the first counter wrap after the write, which is the end of a full output period. Busy clears one cycle after that wrap. From a ratio of 1, busy therefore reads 1 for exactly two cycles.
- R6: A write with the enable bit set while busy is discarded. The drop-error output is 1 for the single cycle after it, and the code being applied is the one from the earlier write.
- R7: For ratios of 2 or more, the output is high for exactly half of each period. For a ratio of 1, the output is the input clock.
- R8: The status word carries busy at bit BUSY_POS, and all its other bits read 0.
- R9: Write-data bits outside the code field and its enable bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_data | input | 32 | Control write data: code field and its enable bit |
| status_word | output | 32 | Status read data, busy at bit BUSY_POS |
| drop_err | output | 1 | One-cycle pulse when an enabled write is discarded |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench builds the divider with SHIFT=5 and BUSY_POS=2, so the code field and its enable bit (bit 21) both sit away from bit 0. This lets a misplaced field, enable or busy bit show up as a wrong ratio or a wrong status word. It also lets the all-ones filler in the other bits test that unrelated bits are ignored. The bench keeps the default three-bit field, so every ratio from 1 to 128 is reachable. Each ratio is measured as a count of output rising edges, and a count of high samples, over a 256-cycle window. The slowest ratio, 128, holds an update pending for long enough to provoke a discarded write.

// File: rtl/rt_clkdiv_pkg.sv
package rt_clkdiv_pkg;

  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_WAIT = 2'd1,
    UPD_DONE = 2'd2
  } upd_state_e;

  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned EN_OFFSET = 16;

endpackage

// File: rtl/rt_clkdiv_ctrl.sv
module rt_clkdiv_ctrl
  import rt_clkdiv_pkg::*;
#(
  parameter int unsigned SHIFT   = 0,
  parameter int unsigned FIELD_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic                wrap,
  output logic                busy,
  output logic                load,
  output logic [FIELD_W-1:0]  pend_code,
  output logic                drop_err
);

  localparam int unsigned EN_POS = SHIFT + EN_OFFSET;

  upd_state_e          state_q, state_d;
  logic [FIELD_W-1:0]  pend_q, pend_d;
  logic                drop_q, drop_d;
  logic                wen, accept, reject;
  logic                unused_wr;

  assign unused_wr = ^wr_data;
  assign wen    = wr_data[EN_POS];
  assign accept = wr_en & wen & (state_q == UPD_IDLE);
  assign reject = wr_en & wen & (state_q != UPD_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      UPD_IDLE: if (accept) state_d = UPD_WAIT;
      UPD_WAIT: if (wrap)   state_d = UPD_DONE;
      UPD_DONE:             state_d = UPD_IDLE;
      default:              state_d = UPD_IDLE;
    endcase
    pend_d = accept ? wr_data[SHIFT +: FIELD_W] : pend_q;
    drop_d = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UPD_IDLE;
      pend_q  <= '0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drop_q  <= drop_d;
      if (accept) pend_q <= pend_d;
    end
  end

  assign busy      = (state_q != UPD_IDLE);
  assign load      = (state_q == UPD_WAIT) & wrap;
  assign pend_code = pend_q;
  assign drop_err  = drop_q;

endmodule

// File: rtl/rt_clkdiv_core.sv
module rt_clkdiv_core #(
  parameter int unsigned FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] pend_code,
  output logic               wrap,
  output logic [FIELD_W-1:0] act_code,
  output logic               clk_out
);

  localparam int unsigned CNT_W = (1 << FIELD_W) - 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FIELD_W-1:0] act_q, act_d;
  logic               div_q, div_d;
  logic [CNT_W:0]     ratio_cur, ratio_nxt, last_cur;

  always_comb begin
    ratio_cur = (CNT_W+1)'(1) << act_q;
    last_cur  = ratio_cur - (CNT_W+1)'(1);
    wrap      = ({1'b0, cnt_q} == last_cur);
    cnt_d     = wrap ? '0 : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    act_d     = load ? pend_code : act_q;
    ratio_nxt = (CNT_W+1)'(1) << act_d;
    if (act_d == '0) div_d = 1'b1;
    else             div_d = ({1'b0, cnt_d} < (ratio_nxt >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      if (load) act_q <= act_d;
    end
  end

  assign act_code = act_q;
  assign clk_out  = (act_q == '0) ? clk : div_q;

endmodule

// File: rtl/rt_clkdiv.sv
module rt_clkdiv
  import rt_clkdiv_pkg::*;
#(
  parameter int unsigned SHIFT    = 0,
  parameter int unsigned FIELD_W  = 3,
  parameter int unsigned BUSY_POS = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] status_word,
  output logic        drop_err,
  output logic        clk_out
);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic               busy, load, wrap;
  logic [FIELD_W-1:0] pend_code, act_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  rt_clkdiv_ctrl #(.SHIFT(SHIFT), .FIELD_W(FIELD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wrap      (wrap),
    .busy      (busy),
    .load      (load),
    .pend_code (pend_code),
    .drop_err  (drop_err)
  );

  rt_clkdiv_core #(.FIELD_W(FIELD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .pend_code (pend_code),
    .wrap      (wrap),
    .act_code  (act_code),
    .clk_out   (clk_out)
  );

  always_comb begin
    status_word           = '0;
    status_word[BUSY_POS] = busy;
  end

endmodule

// File: rtl/rt_clkdiv_chk.sv
module rt_clkdiv_chk #(
  parameter int unsigned SHIFT   = 0,
  parameter int unsigned FIELD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic               busy,
  input logic               drop_err,
  input logic               load,
  input logic               wrap,
  input logic [FIELD_W-1:0] act_code
);

  localparam int unsigned EN_POS = SHIFT + 16;

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[EN_POS] && !busy) |=> busy);

  assert_nowen_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[EN_POS] && !busy) |=> !busy);

  assert_load_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> wrap);

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_code));

  assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(load, 2));

  assert_drop_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[EN_POS] && busy) |=> drop_err);

  assert_no_spurious_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[EN_POS] && busy) |=> !drop_err);

endmodule

bind rt_clkdiv rt_clkdiv_chk #(.SHIFT(SHIFT), .FIELD_W(FIELD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .busy     (busy),
  .drop_err (drop_err),
  .load     (load),
  .wrap     (wrap),
  .act_code (act_code)
);

// File: tb/rt_clkdiv_bench.sv
`timescale 1ns/1ps
module rt_clkdiv_bench;

  localparam int unsigned SHIFT    = 5;
  localparam int unsigned BUSY_POS = 2;
  localparam int unsigned EN_POS   = SHIFT + 16;
  localparam int unsigned WIN      = 256;
  localparam int unsigned NVEC     = 10;

  // {enable, code[2:0], filler}
  localparam logic [4:0] VECS [NVEC] = '{
    5'b1_011_0, 5'b1_111_0, 5'b0_010_0, 5'b1_001_1, 5'b1_000_0,
    5'b1_101_1, 5'b0_110_1, 5'b1_100_0, 5'b1_110_0, 5'b1_010_0
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] status_word;
  logic        drop_err;
  logic        clk_out;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int exp_code = 0;

  always #4 clk = ~clk;

  rt_clkdiv #(.SHIFT(SHIFT), .FIELD_W(3), .BUSY_POS(BUSY_POS)) u_rt_clkdiv (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .status_word (status_word),
    .drop_err    (drop_err),
    .clk_out     (clk_out)
  );

  always @(posedge clk_out) edges <= edges + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_word(input logic en, input logic [2:0] code,
                                            input logic fill);
    logic [31:0] w;
    logic [31:0] keep;
    keep = (32'h7 << SHIFT) | (32'h1 << EN_POS);
    w = fill ? ~keep : 32'h0;
    w[SHIFT +: 3] = code;
    w[EN_POS] = en;
    return w;
  endfunction

  function automatic int busy_of();
    return int'(status_word[BUSY_POS]);
  endfunction

  task automatic do_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'h0;
    #1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status_word[BUSY_POS] && n < 1000) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  task automatic measure(input string req, input int code);
    int e0;
    int hi;
    @(negedge clk);
    #1;
    e0 = edges;
    hi = 0;
    for (int i = 0; i < int'(WIN); i++) begin
      @(negedge clk);
      #1;
      if (clk_out) hi++;
    end
    check({req, " R4 edge count"}, edges - e0, int'(WIN) >> code);
    check({req, " R7 high samples"}, hi, (code == 0) ? 0 : int'(WIN) / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1: reset state, R8: status word empty
    check("R1 busy after reset", busy_of(), 0);
    check("R8 status word after reset", int'(status_word), 0);
    check("R1 drop_err after reset", int'(drop_err), 0);
    measure("R1 reset ratio", 0);

    // vector walk
    for (int v = 0; v < int'(NVEC); v++) begin
      logic en;
      logic [2:0] code;
      logic fill;
      int prev;
      {en, code, fill} = VECS[v];
      prev = exp_code;
      do_write(make_word(en, code, fill));
      check(en ? "R2 busy after enabled write" : "R3 busy after write w/o enable",
            busy_of(), int'(en));
      check("R8 status other bits", int'(status_word & ~(32'h1 << BUSY_POS)), 0);
      check("R6 no drop when idle", int'(drop_err), 0);
      wait_idle(n);
      if (en) begin
        exp_code = int'(code);
        if (prev == 0) check("R5 busy cycles from ratio 1", n, 2);
      end else begin
        check("R3 no busy cycles", n, 0);
      end
      measure(fill ? "R9 filler bits" : "R4 vector", exp_code);
    end

    // R6: discarded write during a slow update
    do_write(make_word(1'b1, 3'd7, 1'b0));
    wait_idle(n);
    exp_code = 7;
    do_write(make_word(1'b1, 3'd1, 1'b0));
    check("R2 busy before overlap", busy_of(), 1);
    do_write(make_word(1'b1, 3'd4, 1'b0));
    check("R6 drop_err pulse", int'(drop_err), 1);
    @(negedge clk);
    #1;
    check("R6 drop_err one cycle", int'(drop_err), 0);
    wait_idle(n);
    exp_code = 1;
    check("R5 busy cleared", busy_of(), 0);
    measure("R6 first write kept", exp_code);

    // R5/R7: back to pass-through then divide again
    do_write(make_word(1'b1, 3'd0, 1'b0));
    wait_idle(n);
    measure("R7 pass-through", 0);
    do_write(make_word(1'b1, 3'd1, 1'b0));
    wait_idle(n);
    check("R5 busy cycles from ratio 1 (second)", n, 2);
    measure("R7 ratio 2", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule